// File: doc/BRIEF.md
# Register-Indexed I2C Target with CRC-8

This block is an I2C target whose 7-bit bus address carries both a group number and a register index. The group is 4 bits and comes from a configuration input. The index is 5 bits. The bus address is the sum of the group shifted left by three and the index. A single address therefore names one of 32 eight-bit registers, so a transfer needs no pointer byte.

A write carries one data byte. A read returns one data byte. When the CRC-enable input is set, every transfer also carries a CRC-8 byte. The CRC covers the address byte and the data byte. The target checks that byte on writes and appends it on reads.

The SCL and SDA inputs pass through synchronisers. SDA is driven as an open-drain output, where a high `sdaOe` pulls the line low. The target never holds SCL low.

Top module: `grpi2c_top`

## Requirements
- R1: The target acknowledges an address byte only when the 7-bit address A satisfies 0 <= A - (groupId * 8) <= 31. The register index is A - (groupId * 8). For any other address it does not drive SDA until the next START.
- R2: The group and the index overlap in address bits 4:3, and the sum may carry. With groupId = 4'b0101, address 0x47 selects index 0x1F and address 0x27 is rejected. With groupId = 4'b0100, address 0x3F selects that same index 0x1F.
- R3: With CRC disabled, a write (R/W bit 0) acknowledges the address and data bytes. The data is stored in the selected register when the data acknowledge clock ends.
- R4: A read (R/W bit 1) shifts the selected register out MSB first. Each bit appears after an SCL falling edge, and SDA changes only while SCL is low.
- R5: With CRC enabled, a write is followed by a CRC byte. If that byte equals the CRC of the address byte and the data byte, the target acknowledges it, stores the data and clears `crcError`.
- R6: With CRC enabled, a CRC byte that does not match is not acknowledged. The register keeps its old value and `crcError` is set. The flag stays set until a later write with a matching CRC.
- R7: With CRC enabled, a read whose data byte the master acknowledges is followed by a CRC byte. This CRC covers the address byte (R/W = 1) and the data byte. If the master does not acknowledge the data byte, SDA stays released and no CRC byte follows.
- R8: The CRC uses polynomial 0x07 (x^8+x^2+x+1). It starts from 0x00, processes bits MSB first, and has no final XOR.
- R9: After reset all 32 registers read 0x00, SDA is released and `crcError` is 0.
- R10: A START or STOP at any point ends the current transfer. A write cut off before its data acknowledge leaves the register unchanged.
- R11: With CRC disabled, a read ends after the data byte even if the master acknowledges it, and SDA stays released for the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as sensed |
| sdaIn | input | 1 | Bus data line as sensed |
| groupId | input | GROUP_W | Group number that places the 32-register window in the address space |
| crcEnable | input | 1 | 1 = CRC byte expected on writes and sent on reads |
| sdaOe | output | 1 | 1 = pull SDA low |
| crcError | output | 1 | Sticky flag, set by a write whose CRC byte did not match |

## Verification
A wrong decode of the window or a lost carry in the subtraction shows at the ACK slot of the address byte. It appears either as a missing acknowledge or as an acknowledge for a foreign address. The directed cases place addresses on both edges of the window and in the carry case.

A corrupt running CRC shows on the very next byte. A write CRC is then left unacknowledged with `crcError` set, or a read returns a CRC byte that differs from the value the bench computes.

A wrong state or an off-by-one in the bit counter shifts or extends SDA driving. This becomes visible within one byte, as a bit read in the wrong position or a line held low during a slot the master owns.

// File: rtl/grpi2c_pkg.sv
package grpi2c_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDATA,
    S_WACK,
    S_WCRC,
    S_WCACK,
    S_RDATA,
    S_RACK,
    S_RCRC,
    S_RCACK,
    S_DONE
  } busState_e;

  // events decoded from the synchronised bus lines
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic takeBit;
    logic latchAddr;
    logic latchData;
    logic ackDrive;
    logic relSda;
    logic loadRead;
    logic loadCrc;
    logic shiftOut;
    logic commit;
    logic setErr;
    logic clrErr;
    logic takeAck;
    logic crcClr;
  } strobe_t;

  function automatic logic [BYTE_W-1:0] crcFold(input logic [BYTE_W-1:0] crcIn,
                                                input logic [BYTE_W-1:0] dataIn);
    logic [BYTE_W-1:0] acc;
    acc = crcIn ^ dataIn;
    for (int i = 0; i < BYTE_W; i++) begin
      acc = acc[BYTE_W-1] ? ({acc[BYTE_W-2:0], 1'b0} ^ CRC_POLY) : {acc[BYTE_W-2:0], 1'b0};
    end
    return acc;
  endfunction

endpackage

// File: rtl/grpi2c_dp.sv
module grpi2c_dp
  import grpi2c_pkg::*;
#(
  parameter int GROUP_W     = 4,
  parameter int INDEX_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [GROUP_W-1:0] groupId,
  input  strobe_t            ctl,
  output busEv_t             ev,
  output logic               byteDone,
  output logic               addrHit,
  output logic               rwBit,
  output logic               crcMatch,
  output logic               ackBit,
  output logic               sdaOe,
  output logic               crcError
);

  localparam int REG_N       = 1 << INDEX_W;
  localparam int GROUP_SHIFT = ADDR_W - GROUP_W;
  localparam int CNT_W       = $clog2(BYTE_W + 1);

  // input synchronisers
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.start = sclS && sclPrev && sdaPrev && !sdaS;
    ev.stop  = sclS && sclPrev && !sdaPrev && sdaS;
    ev.rise  = sclS && !sclPrev;
    ev.fall  = !sclS && sclPrev;
  end

  // byte shifting and decode
  logic [BYTE_W-1:0]  shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic [INDEX_W-1:0] idxReg;
  logic [BYTE_W-1:0]  wrData;
  logic [BYTE_W-1:0]  crcReg;
  logic               rwReg;
  logic [BYTE_W-1:0]  regFile [REG_N];

  logic [ADDR_W:0] groupBase;
  logic [ADDR_W:0] diffAddr;

  assign groupBase = {1'b0, groupId, {GROUP_SHIFT{1'b0}}};
  assign diffAddr  = {1'b0, shiftReg[BYTE_W-1:1]} - groupBase;
  assign addrHit   = (diffAddr[ADDR_W:INDEX_W] == '0);
  assign byteDone  = (bitCnt == CNT_W'(BYTE_W));
  assign crcMatch  = (shiftReg == crcReg);
  assign rwBit     = rwReg;

  logic [BYTE_W-1:0] readByte;
  assign readByte = regFile[idxReg];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.loadRead) begin
      shiftReg <= readByte;
      bitCnt   <= CNT_W'(1);
    end else if (ctl.loadCrc) begin
      shiftReg <= crcReg;
      bitCnt   <= CNT_W'(1);
    end else if (ctl.shiftOut) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      bitCnt   <= bitCnt + 1'b1;
    end else if (ctl.takeBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
      bitCnt   <= bitCnt + 1'b1;
    end else if (ctl.clrCnt) begin
      bitCnt   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      rwReg  <= 1'b0;
      wrData <= '0;
    end else begin
      if (ctl.latchAddr) begin
        idxReg <= diffAddr[INDEX_W-1:0];
        rwReg  <= shiftReg[0];
      end
      if (ctl.latchData) wrData <= shiftReg;
    end
  end

  // running CRC over the bytes of the message
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              crcReg <= '0;
    else if (ctl.crcClr)    crcReg <= '0;
    else if (ctl.latchAddr) crcReg <= crcFold(crcReg, shiftReg);
    else if (ctl.latchData) crcReg <= crcFold(crcReg, shiftReg);
    else if (ctl.loadRead)  crcReg <= crcFold(crcReg, readByte);
  end

  // open-drain data driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sdaOe <= 1'b0;
    else if (ctl.ackDrive)  sdaOe <= 1'b1;
    else if (ctl.loadRead)  sdaOe <= ~readByte[BYTE_W-1];
    else if (ctl.loadCrc)   sdaOe <= ~crcReg[BYTE_W-1];
    else if (ctl.shiftOut)  sdaOe <= ~shiftReg[BYTE_W-2];
    else if (ctl.relSda)    sdaOe <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ackBit <= 1'b1;
    else if (ctl.takeAck) ackBit <= sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           crcError <= 1'b0;
    else if (ctl.setErr) crcError <= 1'b1;
    else if (ctl.clrErr) crcError <= 1'b0;
  end

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) regFile[i] <= '0;
    end else if (ctl.commit) begin
      regFile[idxReg] <= wrData;
    end
  end

endmodule

// File: rtl/grpi2c_ctrl.sv
module grpi2c_ctrl
  import grpi2c_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEv_t    ev,
  input  logic      byteDone,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      crcMatch,
  input  logic      ackBit,
  input  logic      crcEnable,
  output strobe_t   ctl,
  output busState_e state
);

  busState_e nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    ctl = '0;
    if (ev.start) begin
      nxt        = S_ADDR;
      ctl.clrCnt = 1'b1;
      ctl.crcClr = 1'b1;
      ctl.relSda = 1'b1;
    end else if (ev.stop) begin
      nxt        = S_IDLE;
      ctl.relSda = 1'b1;
    end else begin
      unique case (state)
        S_ADDR: begin
          if (ev.rise) ctl.takeBit = 1'b1;
          else if (ev.fall && byteDone) begin
            ctl.latchAddr = 1'b1;
            if (addrHit) begin
              ctl.ackDrive = 1'b1;
              nxt          = S_AACK;
            end else begin
              nxt = S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (ev.fall) begin
            ctl.clrCnt = 1'b1;
            if (rwBit) begin
              ctl.loadRead = 1'b1;
              nxt          = S_RDATA;
            end else begin
              ctl.relSda = 1'b1;
              nxt        = S_WDATA;
            end
          end
        end
        S_WDATA: begin
          if (ev.rise) ctl.takeBit = 1'b1;
          else if (ev.fall && byteDone) begin
            ctl.latchData = 1'b1;
            ctl.ackDrive  = 1'b1;
            nxt           = S_WACK;
          end
        end
        S_WACK: begin
          if (ev.fall) begin
            ctl.relSda = 1'b1;
            ctl.clrCnt = 1'b1;
            if (crcEnable) begin
              nxt = S_WCRC;
            end else begin
              ctl.commit = 1'b1;
              nxt        = S_DONE;
            end
          end
        end
        S_WCRC: begin
          if (ev.rise) ctl.takeBit = 1'b1;
          else if (ev.fall && byteDone) begin
            if (crcMatch) begin
              ctl.ackDrive = 1'b1;
              ctl.commit   = 1'b1;
              ctl.clrErr   = 1'b1;
              nxt          = S_WCACK;
            end else begin
              ctl.setErr = 1'b1;
              nxt        = S_DONE;
            end
          end
        end
        S_WCACK: begin
          if (ev.fall) begin
            ctl.relSda = 1'b1;
            nxt        = S_DONE;
          end
        end
        S_RDATA, S_RCRC: begin
          if (ev.fall) begin
            if (byteDone) begin
              ctl.relSda = 1'b1;
              nxt        = (state == S_RDATA) ? S_RACK : S_RCACK;
            end else begin
              ctl.shiftOut = 1'b1;
            end
          end
        end
        S_RACK: begin
          if (ev.rise) ctl.takeAck = 1'b1;
          else if (ev.fall) begin
            if (!ackBit && crcEnable) begin
              ctl.loadCrc = 1'b1;
              nxt         = S_RCRC;
            end else begin
              nxt = S_DONE;
            end
          end
        end
        S_RCACK: begin
          if (ev.fall) nxt = S_DONE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/grpi2c_top.sv
module grpi2c_top
  import grpi2c_pkg::*;
#(
  parameter int GROUP_W     = 4,
  parameter int INDEX_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [GROUP_W-1:0] groupId,
  input  logic               crcEnable,
  output logic               sdaOe,
  output logic               crcError
);

  busEv_t    busEv;
  strobe_t   strobes;
  busState_e ctrlState;
  logic      byteDone, addrHit, rwBit, crcMatch, ackBit;

  grpi2c_dp #(
    .GROUP_W    (GROUP_W),
    .INDEX_W    (INDEX_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .groupId  (groupId),
    .ctl      (strobes),
    .ev       (busEv),
    .byteDone (byteDone),
    .addrHit  (addrHit),
    .rwBit    (rwBit),
    .crcMatch (crcMatch),
    .ackBit   (ackBit),
    .sdaOe    (sdaOe),
    .crcError (crcError)
  );

  grpi2c_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ev       (busEv),
    .byteDone (byteDone),
    .addrHit  (addrHit),
    .rwBit    (rwBit),
    .crcMatch (crcMatch),
    .ackBit   (ackBit),
    .crcEnable(crcEnable),
    .ctl      (strobes),
    .state    (ctrlState)
  );

endmodule

// File: rtl/grpi2c_chk.sv
module grpi2c_chk
  import grpi2c_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaOe,
  input logic      crcError,
  input logic      crcEnable,
  input busState_e st,
  input strobe_t   ctl
);

  // R4: SDA only moves to a new driven level while SCL is low
  p_sda_moves_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> (!sclIn || !sdaOe));

  // R4: at most one source loads the SDA driver in a cycle
  p_single_driver_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ackDrive, ctl.loadRead, ctl.loadCrc, ctl.shiftOut}));

  // R6: the error flag only rises after a CRC byte was checked
  p_err_after_crc_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcError) |-> (crcEnable && $past(st) == S_WCRC));

  // R1: an acknowledge slot always pulls SDA low
  p_ack_slot_driven_r1: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_AACK || st == S_WACK || st == S_WCACK) |-> sdaOe);

  // R10: an idle or finished target leaves SDA released
  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE || st == S_DONE) |-> !sdaOe);

  // R11: the CRC byte states are only reached with CRC enabled
  p_crc_states_enabled_r11: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_WCRC || st == S_RCRC) |-> crcEnable);

endmodule

bind grpi2c_top grpi2c_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaOe    (sdaOe),
  .crcError (crcError),
  .crcEnable(crcEnable),
  .st       (ctrlState),
  .ctl      (strobes)
);

// File: tb/grpi2c_top_tb.sv
module grpi2c_top_tb;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [3:0] groupId = 4'b0100;
  logic crcEnable = 1'b0;
  logic sdaOe, crcError;
  logic sdaLine;

  int checks = 0;
  int errors = 0;

  assign sdaLine = sdaM & ~sdaOe;

  always #4 clk = ~clk;

  grpi2c_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclM),
    .sdaIn    (sdaLine),
    .groupId  (groupId),
    .crcEnable(crcEnable),
    .sdaOe    (sdaOe),
    .crcError (crcError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // bit-serial reference CRC, polynomial 0x07, zero start, MSB first
  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic busStart();
    tick(2);
    sdaM = 1'b1;
    tick(H);
    sclM = 1'b1;
    tick(H);
    sdaM = 1'b0;
    tick(H);
    sclM = 1'b0;
  endtask

  task automatic busStop();
    tick(2);
    sdaM = 1'b0;
    tick(H);
    sclM = 1'b1;
    tick(H);
    sdaM = 1'b1;
    tick(H);
  endtask

  task automatic putBit(input bit b);
    tick(2);
    sdaM = b;
    tick(H - 2);
    sclM = 1'b1;
    tick(H);
    sclM = 1'b0;
  endtask

  task automatic getBit(output bit b);
    tick(2);
    sdaM = 1'b1;
    tick(H - 2);
    sclM = 1'b1;
    tick(H / 2);
    b = sdaLine;
    tick(H / 2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(a);
    acked = !a;
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(!masterAck);
  endtask

  task automatic doWrite(input logic [6:0] addr, input logic [7:0] data, input bit corrupt,
                         output bit ackA, output bit ackD, output bit ackC);
    logic [7:0] c;
    busStart();
    sendByte({addr, 1'b0}, ackA);
    sendByte(data, ackD);
    ackC = 1'b0;
    if (crcEnable) begin
      c = refCrc(refCrc(8'h00, {addr, 1'b0}), data);
      if (corrupt) c = c ^ 8'h10;
      sendByte(c, ackC);
    end
    busStop();
  endtask

  task automatic doRead(input logic [6:0] addr, input bit ackData,
                        output bit ackA, output logic [7:0] data, output logic [7:0] extra);
    busStart();
    sendByte({addr, 1'b1}, ackA);
    recvByte(ackData, data);
    recvByte(1'b0, extra);
    busStop();
  endtask

  task automatic tReset();
    logic [7:0] d, x;
    bit a;
    check(sdaOe == 1'b0, "R9 sda released after reset", sdaOe, 0);
    check(crcError == 1'b0, "R9 error flag clear after reset", crcError, 0);
    doRead(7'h20, 1'b0, a, d, x);
    check(a, "R9 address ack", a, 1);
    check(d == 8'h00, "R9 register 0 resets to zero", d, 8'h00);
  endtask

  task automatic tPlainWriteRead();
    bit a, d, c;
    logic [7:0] r, x;
    doWrite(7'h25, 8'hA5, 1'b0, a, d, c);
    check(a, "R1 address 0x25 acked in group 4", a, 1);
    check(d, "R3 data byte acked", d, 1);
    doRead(7'h25, 1'b0, a, r, x);
    check(r == 8'hA5, "R3/R4 read back index 5", r, 8'hA5);
    check(x == 8'hFF, "R7 no byte after master NACK", x, 8'hFF);
    doWrite(7'h26, 8'h5A, 1'b0, a, d, c);
    doRead(7'h26, 1'b0, a, r, x);
    check(r == 8'h5A, "R4 MSB-first pattern 0x5A", r, 8'h5A);
    doRead(7'h25, 1'b0, a, r, x);
    check(r == 8'hA5, "R3 neighbour index unchanged", r, 8'hA5);
  endtask

  task automatic tWindowEdges();
    bit a, d, c;
    logic [7:0] r, x;
    doRead(7'h40, 1'b1, a, r, x);
    check(!a, "R1 address 0x40 above window rejected", a, 0);
    check(r == 8'hFF && x == 8'hFF, "R1 no SDA drive after reject", r, 8'hFF);
    doRead(7'h1F, 1'b1, a, r, x);
    check(!a, "R1 address 0x1F below window rejected", a, 0);
    doWrite(7'h20, 8'h77, 1'b0, a, d, c);
    check(a && d, "R1 lowest address 0x20 acked", a, 1);
    doRead(7'h20, 1'b0, a, r, x);
    check(r == 8'h77, "R1 index 0 written", r, 8'h77);
  endtask

  task automatic tCarryGroup();
    bit a, d, c;
    logic [7:0] r, x;
    groupId = 4'b0101;
    doWrite(7'h47, 8'h3C, 1'b0, a, d, c);
    check(a && d, "R2 address 0x47 acked in group 5", a, 1);
    doRead(7'h27, 1'b0, a, r, x);
    check(!a, "R2 address 0x27 rejected in group 5", a, 0);
    groupId = 4'b0100;
    doRead(7'h3F, 1'b0, a, r, x);
    check(a, "R2 address 0x3F acked in group 4", a, 1);
    check(r == 8'h3C, "R2 index 0x1F shared by both groups", r, 8'h3C);
  endtask

  task automatic tCrcWrite();
    bit a, d, c;
    logic [7:0] r, x;
    crcEnable = 1'b1;
    doWrite(7'h2A, 8'hC3, 1'b0, a, d, c);
    check(c, "R5 matching CRC acked", c, 1);
    check(crcError == 1'b0, "R5 no error on good CRC", crcError, 0);
    doRead(7'h2A, 1'b1, a, r, x);
    check(r == 8'hC3, "R5 data stored with good CRC", r, 8'hC3);
    check(x == refCrc(refCrc(8'h00, 8'h55), 8'hC3), "R7/R8 read CRC", x,
          refCrc(refCrc(8'h00, 8'h55), 8'hC3));
    doWrite(7'h2A, 8'h0F, 1'b1, a, d, c);
    check(!c, "R6 bad CRC not acked", c, 0);
    check(crcError == 1'b1, "R6 error flag set", crcError, 1);
    doRead(7'h2A, 1'b0, a, r, x);
    check(r == 8'hC3, "R6 register unchanged", r, 8'hC3);
    check(x == 8'hFF, "R7 no CRC after master NACK", x, 8'hFF);
    check(crcError == 1'b1, "R6 flag stays set across a read", crcError, 1);
    doWrite(7'h2B, 8'h81, 1'b0, a, d, c);
    check(c && crcError == 1'b0, "R5 good write clears flag", crcError, 0);
    doRead(7'h2B, 1'b1, a, r, x);
    check(x == refCrc(refCrc(8'h00, 8'h57), 8'h81), "R8 read CRC second vector", x,
          refCrc(refCrc(8'h00, 8'h57), 8'h81));
    crcEnable = 1'b0;
  endtask

  task automatic tNoCrcAckedRead();
    bit a;
    logic [7:0] r, x;
    doRead(7'h26, 1'b1, a, r, x);
    check(r == 8'h5A, "R11 data byte with CRC off", r, 8'h5A);
    check(x == 8'hFF, "R11 nothing after acked byte", x, 8'hFF);
  endtask

  task automatic tAbort();
    bit a, d, c;
    logic [7:0] r, x;
    doWrite(7'h23, 8'h11, 1'b0, a, d, c);
    busStart();
    sendByte({7'h23, 1'b0}, a);
    for (int i = 0; i < 4; i++) putBit(1'b1);
    busStart();
    busStop();
    doRead(7'h23, 1'b0, a, r, x);
    check(r == 8'h11, "R10 aborted write leaves register", r, 8'h11);
    check(sdaOe == 1'b0, "R10 released after stop", sdaOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    tReset();
    tPlainWriteRead();
    tWindowEdges();
    tCarryGroup();
    tCrcWrite();
    tNoCrcAckedRead();
    tAbort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule